// File: doc/BRIEF.md
# Multicycle Instruction Cycle Controller

This block is the control unit of a small accumulator machine. It carries each instruction through a sequence of machine cycles over one shared memory port. The fetch cycle reads the instruction word. An optional indirect cycle turns an address field into an effective address. The execute cycle performs the operation. An optional interrupt cycle saves the return address to a fixed memory word and redirects the program counter to a handler.

The controller keeps its own program counter, instruction register, memory address register, memory buffer register and accumulator. The memory address register drives the port address, and the memory buffer register drives the port write data. One read strobe and one write strobe request each access. The access finishes on the first clock edge at which the memory raises its ready input, so memory latency can vary from access to access.

Software enables interrupts by pulsing an enable-set input. Taking an interrupt clears the enable again, so a request line that stays high causes exactly one entry into the handler.

Top module: `instr_cycle_ctrl`

## Requirements
- R1: While the synchronous active-high reset is applied, and in the first cycle after it, the controller requests a read at address 0 with the write strobe low. The accumulator is zero and interrupts are disabled, so a raised request line has no effect until interrupts are enabled.
- R2: A fetch reads the word at the program counter into the instruction register and adds one to the program counter (modulo 2^ADDR_W). When no jump or interrupt intervenes, the next fetch reads the following address.
- R3: A pending access keeps its address, strobes and write data unchanged until the edge at which mem_ready is high, whatever the number of wait cycles.
- R4: The instruction word has three fields. The most significant bit is the indirect flag. The OPC_W bits directly above the address field are the opcode. The low ADDR_W bits are the address field; at the defaults this is bit 11, bits 10:8 and bits 7:0. When the flag is set, one extra read is made at the address field, and the low ADDR_W bits of the returned word become the effective address.
- R5: Opcode 0 loads the word at the effective address into the accumulator. Opcode 2 adds that word to the accumulator modulo 2^DATA_W. Opcode 1 writes the accumulator to the effective address.
- R6: Opcode 3 loads the effective address into the program counter and makes no memory access during its execute cycle. Opcodes 4 to 7 make no memory access and change nothing.
- R7: After an execute cycle, when the interrupt enable is set and irq is high, the controller writes the program counter (the address of the next instruction) to SAVE_ADDR. It then fetches from ISR_ADDR. Otherwise it goes straight to the next fetch.
- R8: Entering the interrupt cycle clears the interrupt enable, and this clear wins over a set pulse in the same cycle. A one-cycle pulse on ie_set sets the enable again.
- R9: The read and write strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | DATA_W | Word returned by memory for the pending read |
| mem_ready | input | 1 | Memory finishes the pending access at this edge |
| irq | input | 1 | Level-sensitive interrupt request |
| ie_set | input | 1 | One-cycle pulse that sets the interrupt enable |
| mem_addr | output | ADDR_W | Access address (memory address register) |
| mem_wdata | output | DATA_W | Write data (memory buffer register) |
| mem_rd | output | 1 | Read request strobe |
| mem_wr | output | 1 | Write request strobe |

## Verification
The hardest case to reach from the ports is the interrupt decision. It is made on the single edge that ends an execute cycle. It depends on an internal enable flag, on whatever the request line holds at that edge, and on memory stalls that move the edge around. The stimulus runs the program into a tight jump loop, so execute cycles end every few clocks. It then holds irq high across set pulses, both without enable and with enable. A behavioural model that samples irq at the same edges predicts every access. Counting the writes to the save word shows that a request held high enters the handler exactly once for each enable pulse.

// File: rtl/icc_pkg.sv
package icc_pkg;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_INDIR = 2'd1,
    ST_EXEC  = 2'd2,
    ST_INTR  = 2'd3
  } cyc_e;

  localparam int OPC_LOAD  = 0;
  localparam int OPC_STORE = 1;
  localparam int OPC_ADD   = 2;
  localparam int OPC_JUMP  = 3;

endpackage

// File: rtl/icc_decode.sv
module icc_decode #(
  parameter int ADDR_W = 8,
  parameter int OPC_W  = 3,
  parameter int DATA_W = 1 + OPC_W + ADDR_W
) (
  input  logic [DATA_W-1:0] word,
  output logic              ind,
  output logic [OPC_W-1:0]  op,
  output logic [ADDR_W-1:0] addr,
  output logic              uses_rd,
  output logic              uses_wr,
  output logic              is_jump
);
  import icc_pkg::*;

  localparam int OP_LO = ADDR_W;
  localparam int OP_HI = ADDR_W + OPC_W - 1;

  always_comb begin
    ind     = word[DATA_W-1];
    op      = word[OP_HI:OP_LO];
    addr    = word[ADDR_W-1:0];
    uses_rd = (op == OPC_W'(OPC_LOAD)) || (op == OPC_W'(OPC_ADD));
    uses_wr = (op == OPC_W'(OPC_STORE));
    is_jump = (op == OPC_W'(OPC_JUMP));
  end
endmodule

// File: rtl/icc_acc_unit.sv
module icc_acc_unit #(
  parameter int OPC_W  = 3,
  parameter int DATA_W = 12
) (
  input  logic [OPC_W-1:0]  op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] acc_next
);
  import icc_pkg::*;

  always_comb begin
    if (op == OPC_W'(OPC_LOAD))     acc_next = operand;
    else if (op == OPC_W'(OPC_ADD)) acc_next = acc + operand;
    else                            acc_next = acc;
  end
endmodule

// File: rtl/instr_cycle_ctrl.sv
module instr_cycle_ctrl #(
  parameter int ADDR_W    = 8,
  parameter int OPC_W     = 3,
  parameter int DATA_W    = 1 + OPC_W + ADDR_W,
  parameter int SAVE_ADDR = 240,
  parameter int ISR_ADDR  = 192
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  input  logic              irq,
  input  logic              ie_set,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr
);
  import icc_pkg::*;

  localparam logic [ADDR_W-1:0] SAVE_A = ADDR_W'(SAVE_ADDR);
  localparam logic [ADDR_W-1:0] ISR_A  = ADDR_W'(ISR_ADDR);

  cyc_e              st, st_n;
  logic [ADDR_W-1:0] pc, pc_n, mar, mar_n;
  logic [DATA_W-1:0] ir, ir_n, mbr, mbr_n, acc, acc_n;
  logic              rd, rd_n, wr, wr_n, ie, ie_n;

  // decoded view of the word on the bus and of the held instruction
  logic              dm_ind, dm_rd, dm_wr, dm_jump;
  logic [OPC_W-1:0]  dm_op;
  logic [ADDR_W-1:0] dm_addr;
  logic              di_ind, di_rd, di_wr, di_jump;
  logic [OPC_W-1:0]  di_op;
  logic [ADDR_W-1:0] di_addr;
  logic [DATA_W-1:0] acc_nxt;

  // sequencing helpers
  logic              go_exec, finish, ex_rd, ex_wr;
  logic [ADDR_W-1:0] ex_ea;

  icc_decode #(.ADDR_W(ADDR_W), .OPC_W(OPC_W), .DATA_W(DATA_W)) u_dec_bus (
    .word(mem_rdata), .ind(dm_ind), .op(dm_op), .addr(dm_addr),
    .uses_rd(dm_rd), .uses_wr(dm_wr), .is_jump(dm_jump)
  );

  icc_decode #(.ADDR_W(ADDR_W), .OPC_W(OPC_W), .DATA_W(DATA_W)) u_dec_ir (
    .word(ir), .ind(di_ind), .op(di_op), .addr(di_addr),
    .uses_rd(di_rd), .uses_wr(di_wr), .is_jump(di_jump)
  );

  icc_acc_unit #(.OPC_W(OPC_W), .DATA_W(DATA_W)) u_acc (
    .op(di_op), .acc(acc), .operand(mem_rdata), .acc_next(acc_nxt)
  );

  always_comb begin
    st_n    = st;
    pc_n    = pc;
    ir_n    = ir;
    acc_n   = acc;
    mar_n   = mar;
    mbr_n   = mbr;
    rd_n    = rd;
    wr_n    = wr;
    ie_n    = ie | ie_set;
    go_exec = 1'b0;
    finish  = 1'b0;
    ex_ea   = '0;
    ex_rd   = 1'b0;
    ex_wr   = 1'b0;

    unique case (st)
      ST_FETCH: begin
        if (mem_ready) begin
          ir_n  = mem_rdata;
          mbr_n = mem_rdata;
          pc_n  = pc + ADDR_W'(1);
          rd_n  = 1'b0;
          if (dm_ind) begin
            st_n  = ST_INDIR;
            mar_n = dm_addr;
            rd_n  = 1'b1;
          end else begin
            go_exec = 1'b1;
            ex_ea   = dm_addr;
            ex_rd   = dm_rd;
            ex_wr   = dm_wr;
          end
        end
      end
      ST_INDIR: begin
        if (mem_ready) begin
          mbr_n   = mem_rdata;
          rd_n    = 1'b0;
          go_exec = 1'b1;
          ex_ea   = mem_rdata[ADDR_W-1:0];
          ex_rd   = di_rd;
          ex_wr   = di_wr;
        end
      end
      ST_EXEC: begin
        if (rd) begin
          if (mem_ready) begin
            mbr_n  = mem_rdata;
            acc_n  = acc_nxt;
            rd_n   = 1'b0;
            finish = 1'b1;
          end
        end else if (wr) begin
          if (mem_ready) begin
            wr_n   = 1'b0;
            finish = 1'b1;
          end
        end else begin
          if (di_jump) pc_n = mar;
          finish = 1'b1;
        end
      end
      ST_INTR: begin
        if (mem_ready) begin
          wr_n  = 1'b0;
          pc_n  = ISR_A;
          st_n  = ST_FETCH;
          mar_n = ISR_A;
          rd_n  = 1'b1;
        end
      end
      default: st_n = ST_FETCH;
    endcase

    // launch the execute access on the same edge the operand address is known
    if (go_exec) begin
      st_n  = ST_EXEC;
      mar_n = ex_ea;
      rd_n  = ex_rd;
      wr_n  = ex_wr;
      if (ex_wr) mbr_n = acc;
    end

    // choose between the interrupt cycle and the next fetch
    if (finish) begin
      if (ie && irq) begin
        st_n  = ST_INTR;
        mar_n = SAVE_A;
        mbr_n = DATA_W'(pc_n);
        wr_n  = 1'b1;
        rd_n  = 1'b0;
        ie_n  = 1'b0;
      end else begin
        st_n  = ST_FETCH;
        mar_n = pc_n;
        rd_n  = 1'b1;
        wr_n  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_FETCH;
      pc  <= '0;
      ir  <= '0;
      acc <= '0;
      mar <= '0;
      mbr <= '0;
      rd  <= 1'b1;
      wr  <= 1'b0;
      ie  <= 1'b0;
    end else begin
      st  <= st_n;
      pc  <= pc_n;
      ir  <= ir_n;
      acc <= acc_n;
      mar <= mar_n;
      mbr <= mbr_n;
      rd  <= rd_n;
      wr  <= wr_n;
      ie  <= ie_n;
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign mem_rd    = rd;
  assign mem_wr    = wr;

  // R3: a stalled access keeps every port value
  a_r3_hold_on_wait: assert property (@(posedge clk) disable iff (rst)
    ((mem_rd || mem_wr) && !mem_ready) |=>
      ($stable(mem_addr) && $stable(mem_rd) && $stable(mem_wr) && $stable(mem_wdata)));

  // R9: never both strobes
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, mem_wr}));

  // R2: a completed fetch advances the program counter by one
  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FETCH && mem_ready) |=> (pc == $past(pc) + ADDR_W'(1)));

  // R4: the indirect cycle is a read
  a_r4_indirect_reads: assert property (@(posedge clk) disable iff (rst)
    (st == ST_INDIR) |-> (mem_rd && !mem_wr));

  // R7: the interrupt cycle writes the save word
  a_r7_save_target: assert property (@(posedge clk) disable iff (rst)
    (st == ST_INTR) |-> (mem_wr && mem_addr == SAVE_A));

  // R8: the enable is off throughout the interrupt cycle
  a_r8_enable_cleared: assert property (@(posedge clk) disable iff (rst)
    (st == ST_INTR) |-> !ie);

endmodule

// File: tb/sim_instr_cycle_ctrl.sv
module sim_instr_cycle_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int OW = 3;
  localparam int DW = 1 + OW + AW;
  localparam logic [AW-1:0] SAVE = 8'hF0;
  localparam logic [AW-1:0] ISR  = 8'hC0;

  logic          clk = 1'b0;
  logic          rst, irq, ie_set, mem_ready;
  logic [DW-1:0] mem_rdata, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr;

  int tests = 0;
  int fails = 0;
  int saves = 0;
  bit fast  = 1'b1;
  logic [15:0] lfsr = 16'hACE1;

  logic [DW-1:0] mem [0:255];

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_cycle_ctrl #(.ADDR_W(AW), .OPC_W(OW), .SAVE_ADDR(240), .ISR_ADDR(192)) u0 (
    .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .irq(irq), .ie_set(ie_set), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr)
  );

  // memory with variable latency
  assign mem_rdata = mem[mem_addr];

  always @(negedge clk) begin
    lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready <= fast | lfsr[0] | lfsr[3];
  end

  always @(posedge clk) begin
    if (!rst && mem_wr && mem_ready) begin
      mem[mem_addr] <= mem_wdata;
      if (mem_addr == SAVE) saves <= saves + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model: phases 0 fetch, 1 indirect, 2 execute, 3 interrupt
  int            m_phase;
  logic [AW-1:0] m_pc, e_addr;
  logic [DW-1:0] m_acc, m_ir, e_data, w;
  bit            m_ie, ie_nx, m_pend, m_wait, e_rd, e_wr;

  function automatic int op_of(input logic [DW-1:0] x);
    return int'(x[AW+OW-1:AW]);
  endfunction

  task m_finish();
    if (m_ie && irq) begin
      m_phase = 3; e_rd = 0; e_wr = 1; e_addr = SAVE; e_data = DW'(m_pc); ie_nx = 0;
    end else begin
      m_phase = 0; e_rd = 1; e_wr = 0; e_addr = m_pc;
    end
  endtask

  task m_start_exec(input logic [AW-1:0] ea);
    m_phase = 2;
    e_addr  = ea;
    case (op_of(m_ir))
      0, 2:    begin e_rd = 1; e_wr = 0; end
      1:       begin e_rd = 0; e_wr = 1; e_data = m_acc; end
      default: begin e_rd = 0; e_wr = 0; m_pend = 1; end
    endcase
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_pc = 0; m_acc = 0; m_ir = 0; m_ie = 0; m_pend = 0;
      e_rd = 1; e_wr = 0; e_addr = 0; e_data = 0; m_wait = 0;
    end else begin
      ie_nx  = m_ie | ie_set;
      m_wait = 0;
      if (m_pend) begin
        m_pend = 0;
        if (op_of(m_ir) == 3) m_pc = e_addr;
        m_finish();
      end else if (!mem_ready) begin
        m_wait = 1;
      end else begin
        case (m_phase)
          0: begin
            w = mem[e_addr]; m_ir = w; m_pc = m_pc + 1'b1;
            if (w[DW-1]) begin m_phase = 1; e_rd = 1; e_wr = 0; e_addr = w[AW-1:0]; end
            else m_start_exec(w[AW-1:0]);
          end
          1: begin w = mem[e_addr]; m_start_exec(w[AW-1:0]); end
          2: begin
            if (e_rd) begin
              if (op_of(m_ir) == 0) m_acc = mem[e_addr];
              else m_acc = m_acc + mem[e_addr];
            end
            m_finish();
          end
          default: begin m_pc = ISR; m_phase = 0; e_rd = 1; e_wr = 0; e_addr = ISR; end
        endcase
      end
      m_ie = ie_nx;
    end
  end

  // per-clock comparison, sampled after the edge has settled
  always begin
    @(posedge clk);
    #2;
    if (!rst) begin
      chk(!(mem_rd && mem_wr), "R9", {mem_rd, mem_wr}, 0);
      if (m_pend)
        chk(!mem_rd && !mem_wr, "R6", {mem_rd, mem_wr}, 0);
      else
        chk(mem_rd == e_rd && mem_wr == e_wr && mem_addr == e_addr && (!e_wr || mem_wdata == e_data),
            m_wait ? "R3" : (m_phase == 0 ? "R2" : (m_phase == 1 ? "R4" : (m_phase == 2 ? "R5" : "R7"))),
            {mem_rd, mem_wr, mem_addr, mem_wdata}, {e_rd, e_wr, e_addr, e_wr ? e_data : mem_wdata});
    end
  end

  function automatic logic [DW-1:0] enc(input bit ind, input int op, input int a);
    return {ind, OW'(op), AW'(a)};
  endfunction

  task pulse_ie();
    @(negedge clk); ie_set = 1;
    @(negedge clk); ie_set = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL R2 watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[8'h00] = enc(0, 0, 8'h80);   // load
    mem[8'h01] = enc(1, 2, 8'h81);   // add, indirect
    mem[8'h02] = enc(0, 1, 8'h90);   // store
    mem[8'h03] = enc(1, 3, 8'h83);   // jump, indirect
    mem[8'h10] = enc(0, 2, 8'h80);
    mem[8'h11] = enc(0, 1, 8'h91);
    mem[8'h12] = enc(0, 5, 8'h00);   // no-op opcode
    mem[8'h13] = enc(0, 3, 8'h13);   // tight loop
    mem[8'hC0] = enc(0, 0, 8'h84);
    mem[8'hC1] = enc(0, 1, 8'h92);
    mem[8'hC2] = enc(1, 3, 8'hF0);   // return through saved word
    mem[8'h80] = 12'd5;
    mem[8'h81] = 12'h082;
    mem[8'h82] = 12'd7;
    mem[8'h83] = 12'h010;
    mem[8'h84] = 12'h2A5;

    rst = 1; irq = 0; ie_set = 0;
    repeat (3) @(negedge clk);
    chk(mem_rd && !mem_wr && mem_addr == 0, "R1", {mem_rd, mem_wr, mem_addr}, {2'b10, 8'h00});
    irq = 1;                          // interrupts still disabled after reset
    fast = 0;
    rst = 0;
    repeat (200) @(negedge clk);
    chk(saves == 0, "R1", saves, 0);
    chk(mem[8'h90] == 12'd12, "R4", mem[8'h90], 12);
    chk(mem[8'h91] == 12'd17, "R5", mem[8'h91], 17);

    pulse_ie();                       // irq held high: exactly one entry
    repeat (200) @(negedge clk);
    chk(saves == 1, "R8", saves, 1);
    chk(mem[SAVE] == 12'h013, "R7", mem[SAVE], 12'h013);
    chk(mem[8'h92] == 12'h2A5, "R7", mem[8'h92], 12'h2A5);

    pulse_ie();
    repeat (200) @(negedge clk);
    chk(saves == 2, "R8", saves, 2);

    irq = 0;                          // enabled but no request
    pulse_ie();
    repeat (200) @(negedge clk);
    chk(saves == 2, "R7", saves, 2);

    rst = 1;
    repeat (2) @(negedge clk);
    chk(mem_rd && !mem_wr && mem_addr == 0, "R1", {mem_rd, mem_wr, mem_addr}, {2'b10, 8'h00});
    mem[8'h90] = '0;
    fast = 1;
    rst = 0;
    repeat (200) @(negedge clk);
    chk(mem[8'h90] == 12'd12, "R5", mem[8'h90], 12);
    chk(saves == 2, "R1", saves, 2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule